// File: doc/BRIEF.md
# Channel-Status Block Marker and C/U Serial Output

This block sits behind an AES3 subframe decoder. For each decoded subframe it receives a one-cycle strobe, a preamble type code and that subframe's channel-status (C) and user (U) bits. It produces three things:

- A frame-rate word clock with 50% duty.
- Serial C and U outputs that change only on that clock's edges. Subframe A bits are driven from a rising edge and subframe B bits from the following falling edge.
- A block marker that rises two frames after a block-start (Z) preamble and stays high for sixteen frames.

The word clock has two sources. In master mode a divider counts system clocks to produce it. In slave mode it is an externally supplied level, brought in through a synchronizer. In both modes the selected clock is retimed, so that the word clock output and the C, U and marker outputs leave the block from registers in the same cycle. A hardware-control enable gates the C output and the block marker. The U output is not affected by that enable.

Top module: `cs_cu_out`

## Requirements
- R1: While `rst_i` is high, `wclk_o`, `c_o`, `u_o` and `blk_mark_o` are all 0.
- R2: With `master_i` = 1, `wclk_o` alternates high and low phases of exactly FRAME_CYCLES/2 clock cycles each.
- R3: With `master_i` = 0, `wclk_o` follows `wclk_ext_i` after SYNC_STAGES+2 rising edges of `clk_i`. With the default of 2 stages, a level driven before edge 1 is seen on `wclk_o` after edge 4.
- R4: `c_o` and `u_o` change only in cycles in which `wclk_o` changes, and `blk_mark_o` changes only in cycles in which `wclk_o` rises.
- R5: The preamble code `sf_pre_i` is encoded as 1 = Z, 2 = X, 3 = Y. At each `wclk_o` rising edge, `c_o` and `u_o` show the bits of the most recent Z or X subframe. At each falling edge they show the bits of the most recent Y subframe. A subframe must arrive at least 3 cycles before the edge that shows it.
- R6: Until the first Z subframe has been received, `c_o`, `u_o` and `blk_mark_o` stay 0, whatever the other subframes carry.
- R7: If the last Z subframe arrived during frame n, `blk_mark_o` rises at the `wclk_o` rising edge that begins frame n+2. A frame begins at a `wclk_o` rising edge.
- R8: `blk_mark_o` stays high for 16 frames and falls at the rising edge that begins frame n+18.
- R9: A Z subframe that arrives while the marker is running restarts both the delay and the width count. The marker falls at the next rising edge and rises again two frames after the new Z.
- R10: While `hw_mode_i` = 0, `c_o` and `blk_mark_o` are driven 0 from the next word-clock edge, and `u_o` keeps following R5. When `hw_mode_i` returns to 1, the marker resumes at the next rising edge if it is still inside its window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| master_i | input | 1 | 1 = internal word clock divider, 0 = external word clock |
| hw_mode_i | input | 1 | Hardware-control enable for C and block marker |
| wclk_ext_i | input | 1 | External word clock (slave mode), asynchronous |
| sf_valid_i | input | 1 | One-cycle strobe per decoded subframe |
| sf_pre_i | input | 2 | Preamble code: 1 = Z, 2 = X, 3 = Y |
| sf_c_i | input | 1 | Channel-status bit of the subframe |
| sf_u_i | input | 1 | User bit of the subframe |
| wclk_o | output | 1 | Frame-rate word clock, 50% duty in master mode |
| c_o | output | 1 | Serial channel-status output |
| u_o | output | 1 | Serial user-bit output |
| blk_mark_o | output | 1 | Block boundary marker |

## Verification
A vector table drives one frame per entry. The entries mix three kinds of subframe: X subframes with ones before any Z, Z subframes carrying distinct C/U pairs, and frames that skip subframe A or subframe B. These patterns tell apart a design that emits bits before block start, one that swaps the A and B edges, and one that fails to hold the last value. A second Z lands in the middle of the marker window, which separates a restarting counter from a free-running one. A hardware-mode-off stretch separates C gating from U gating. A slave-mode run uses an external clock at a different rate from the divider, and follows one marker to its fall at frame n+18.

// File: rtl/cs_cu_pkg.sv
package cs_cu_pkg;

  typedef enum logic [1:0] {
    PRE_NONE = 2'd0,
    PRE_Z    = 2'd1,
    PRE_X    = 2'd2,
    PRE_Y    = 2'd3
  } pre_t;

  typedef enum logic [1:0] {
    MK_IDLE   = 2'd0,
    MK_DELAY  = 2'd1,
    MK_ACTIVE = 2'd2
  } mk_state_t;

  typedef struct packed {
    logic c;
    logic u;
  } cu_t;

endpackage

// File: rtl/cs_cu_wclk.sv
module cs_cu_wclk #(
  parameter int FRAME_CYCLES = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic master_i,
  input  logic wclk_ext_i,
  output logic rise_o,
  output logic fall_o,
  output logic level_o
);

  localparam int HALF = FRAME_CYCLES / 2;
  localparam int PH_W = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;

  logic [PH_W-1:0]        ph_q;
  logic                   gen_lvl;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sel_lvl;
  logic                   prev_q;

  // Phase divider for master mode
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ph_q <= '0;
    end else if (ph_q == PH_W'(FRAME_CYCLES - 1)) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign gen_lvl = (ph_q < PH_W'(HALF));

  // Synchronizer for the external word clock
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '0;
    end else begin
      for (int i = SYNC_STAGES - 1; i > 0; i--) begin
        sync_q[i] <= sync_q[i-1];
      end
      sync_q[0] <= wclk_ext_i;
    end
  end

  assign sel_lvl = master_i ? gen_lvl : sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= sel_lvl;
    end
  end

  assign rise_o  = sel_lvl & ~prev_q;
  assign fall_o  = ~sel_lvl & prev_q;
  assign level_o = prev_q;

endmodule

// File: rtl/cs_cu_marker.sv
module cs_cu_marker
  import cs_cu_pkg::*;
#(
  parameter int DELAY_FRAMES = 2,
  parameter int WIDTH_FRAMES = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic z_i,
  input  logic tick_i,
  output logic mark_o
);

  localparam int CNT_MAX = (DELAY_FRAMES > WIDTH_FRAMES) ? DELAY_FRAMES : WIDTH_FRAMES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  mk_state_t  state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic pend_q, pend_d;
  logic mark_q, mark_d;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mark_d  = mark_q;
    pend_d  = pend_q | z_i;
    if (tick_i) begin
      if (pend_q) begin
        // Z seen in the previous frame: this tick is the first counted frame
        pend_d = z_i;
        if (DELAY_FRAMES <= 1) begin
          state_d = MK_ACTIVE;
          cnt_d   = '0;
          mark_d  = 1'b1;
        end else begin
          state_d = MK_DELAY;
          cnt_d   = CNT_W'(1);
          mark_d  = 1'b0;
        end
      end else begin
        unique case (state_q)
          MK_DELAY: begin
            if (cnt_inc == CNT_W'(DELAY_FRAMES)) begin
              state_d = MK_ACTIVE;
              cnt_d   = '0;
              mark_d  = 1'b1;
            end else begin
              cnt_d = cnt_inc;
            end
          end
          MK_ACTIVE: begin
            if (cnt_inc == CNT_W'(WIDTH_FRAMES)) begin
              state_d = MK_IDLE;
              cnt_d   = '0;
              mark_d  = 1'b0;
            end else begin
              cnt_d = cnt_inc;
            end
          end
          default: begin
            state_d = MK_IDLE;
            cnt_d   = '0;
            mark_d  = 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= MK_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      mark_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      mark_q  <= mark_d;
    end
  end

  assign mark_o = mark_q;

endmodule

// File: rtl/cs_cu_ser.sv
module cs_cu_ser
  import cs_cu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       sf_valid_i,
  input  logic [1:0] sf_pre_i,
  input  logic       sf_c_i,
  input  logic       sf_u_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       hw_mode_i,
  output logic       c_o,
  output logic       u_o
);

  cu_t  hold_a_q, hold_b_q;
  logic seen_q;
  logic c_q, u_q;
  logic is_a, is_b, is_z;

  assign is_z = sf_valid_i && (pre_t'(sf_pre_i) == PRE_Z);
  assign is_a = sf_valid_i && ((pre_t'(sf_pre_i) == PRE_Z) || (pre_t'(sf_pre_i) == PRE_X));
  assign is_b = sf_valid_i && (pre_t'(sf_pre_i) == PRE_Y);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hold_a_q <= '0;
      hold_b_q <= '0;
      seen_q   <= 1'b0;
    end else begin
      if (is_a) hold_a_q <= '{c: sf_c_i, u: sf_u_i};
      if (is_b) hold_b_q <= '{c: sf_c_i, u: sf_u_i};
      if (is_z) seen_q   <= 1'b1;
    end
  end

  // Bits leave only at word-clock edges; gating is applied there too
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      c_q <= 1'b0;
      u_q <= 1'b0;
    end else if (rise_i) begin
      c_q <= hw_mode_i & seen_q & hold_a_q.c;
      u_q <= seen_q & hold_a_q.u;
    end else if (fall_i) begin
      c_q <= hw_mode_i & seen_q & hold_b_q.c;
      u_q <= seen_q & hold_b_q.u;
    end
  end

  assign c_o = c_q;
  assign u_o = u_q;

endmodule

// File: rtl/cs_cu_out.sv
module cs_cu_out
  import cs_cu_pkg::*;
#(
  parameter int FRAME_CYCLES = 64,
  parameter int SYNC_STAGES  = 2,
  parameter int DELAY_FRAMES = 2,
  parameter int WIDTH_FRAMES = 16
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       master_i,
  input  logic       hw_mode_i,
  input  logic       wclk_ext_i,
  input  logic       sf_valid_i,
  input  logic [1:0] sf_pre_i,
  input  logic       sf_c_i,
  input  logic       sf_u_i,
  output logic       wclk_o,
  output logic       c_o,
  output logic       u_o,
  output logic       blk_mark_o
);

  logic rise, fall, level;
  logic z_strobe;
  logic mark_int;
  logic c_int, u_int;
  logic rise_d_q;

  assign z_strobe = sf_valid_i && (pre_t'(sf_pre_i) == PRE_Z);

  cs_cu_wclk #(
    .FRAME_CYCLES(FRAME_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) wclk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .master_i  (master_i),
    .wclk_ext_i(wclk_ext_i),
    .rise_o    (rise),
    .fall_o    (fall),
    .level_o   (level)
  );

  cs_cu_marker #(
    .DELAY_FRAMES(DELAY_FRAMES),
    .WIDTH_FRAMES(WIDTH_FRAMES)
  ) marker_i (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .z_i   (z_strobe),
    .tick_i(rise),
    .mark_o(mark_int)
  );

  cs_cu_ser ser_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sf_valid_i(sf_valid_i),
    .sf_pre_i  (sf_pre_i),
    .sf_c_i    (sf_c_i),
    .sf_u_i    (sf_u_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .hw_mode_i (hw_mode_i),
    .c_o       (c_int),
    .u_o       (u_int)
  );

  // Output stage: all four outputs leave from registers in the same cycle
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wclk_o     <= 1'b0;
      c_o        <= 1'b0;
      u_o        <= 1'b0;
      blk_mark_o <= 1'b0;
      rise_d_q   <= 1'b0;
    end else begin
      wclk_o   <= level;
      c_o      <= c_int;
      u_o      <= u_int;
      rise_d_q <= rise;
      if (rise_d_q) blk_mark_o <= hw_mode_i & mark_int;
    end
  end

endmodule

// File: rtl/cs_cu_out_chk.sv
module cs_cu_out_chk #(
  parameter int FRAME_CYCLES = 64,
  parameter int WIDTH_FRAMES = 16
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       master_i,
  input logic       sf_valid_i,
  input logic [1:0] sf_pre_i,
  input logic       wclk_o,
  input logic       c_o,
  input logic       u_o,
  input logic       blk_mark_o
);

  localparam int HALF = FRAME_CYCLES / 2;

  logic        seen_q;
  logic        wlast_q;
  logic [15:0] run_q, run_c;
  logic [15:0] hi_q, hi_c;

  always_comb begin
    run_c = (wclk_o != wlast_q) ? 16'd1 : run_q + 16'd1;
    if (!blk_mark_o)             hi_c = 16'd0;
    else if (wclk_o && !wlast_q) hi_c = hi_q + 16'd1;
    else                         hi_c = hi_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      seen_q  <= 1'b0;
      wlast_q <= 1'b0;
      run_q   <= 16'd0;
      hi_q    <= 16'd0;
    end else begin
      if (sf_valid_i && sf_pre_i == 2'd1) seen_q <= 1'b1;
      wlast_q <= wclk_o;
      run_q   <= run_c;
      hi_q    <= hi_c;
    end
  end

  assert_cu_on_edge_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$stable(c_o) || !$stable(u_o)) |-> !$stable(wclk_o));

  assert_mark_on_rise_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(blk_mark_o) |-> $rose(wclk_o));

  assert_quiet_before_z_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !seen_q |-> !(c_o || u_o || blk_mark_o));

  assert_half_period_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    master_i |-> (run_c <= 16'(HALF)));

  assert_mark_width_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    blk_mark_o |-> (hi_c <= 16'(WIDTH_FRAMES)));

endmodule

bind cs_cu_out cs_cu_out_chk #(
  .FRAME_CYCLES(FRAME_CYCLES),
  .WIDTH_FRAMES(WIDTH_FRAMES)
) chk_i (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .master_i  (master_i),
  .sf_valid_i(sf_valid_i),
  .sf_pre_i  (sf_pre_i),
  .wclk_o    (wclk_o),
  .c_o       (c_o),
  .u_o       (u_o),
  .blk_mark_o(blk_mark_o)
);

// File: tb/cs_cu_out_tb_top.sv
module cs_cu_out_tb_top;

  localparam int FC   = 16;
  localparam int HALF = FC / 2;
  localparam int EXT_HALF = 12;

  // vector bits: [6] send A, [5] A is Z (else X), [4] send B, [3] A.c, [2] A.u, [1] B.c, [0] B.u
  localparam logic [6:0] VEC [32] = '{
    7'h5F, 7'h00, 7'h79, 7'h56, 7'h5C, 7'h13, 7'h40, 7'h5F,
    7'h56, 7'h00, 7'h5C, 7'h13, 7'h77, 7'h56, 7'h5F, 7'h40,
    7'h13, 7'h5C, 7'h00, 7'h56, 7'h00, 7'h00, 7'h00, 7'h00,
    7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00
  };

  logic clk = 1'b0;
  logic rst, master, hw_mode, wclk_ext;
  logic sf_valid, sf_c, sf_u;
  logic [1:0] sf_pre;
  logic wclk_o, c_o, u_o, blk_mark_o;

  int nchk = 0, nfail = 0;
  bit done = 0;
  bit ext_run = 0;
  int ext_cnt = 0;

  // model
  bit seen, restarted, hw;
  int lastz, frame_n;
  logic mac, mau, mbc, mbu;

  always #2.5 clk = ~clk;

  cs_cu_out #(.FRAME_CYCLES(FC)) dut_i (
    .clk_i(clk), .rst_i(rst), .master_i(master), .hw_mode_i(hw_mode),
    .wclk_ext_i(wclk_ext), .sf_valid_i(sf_valid), .sf_pre_i(sf_pre),
    .sf_c_i(sf_c), .sf_u_i(sf_u), .wclk_o(wclk_o), .c_o(c_o), .u_o(u_o),
    .blk_mark_o(blk_mark_o)
  );

  always @(negedge clk) begin
    if (ext_run) begin
      ext_cnt = ext_cnt + 1;
      if (ext_cnt == EXT_HALF) begin
        wclk_ext = ~wclk_ext;
        ext_cnt = 0;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_level(input logic lvl);
    do @(negedge clk); while (wclk_o !== lvl);
  endtask

  task automatic inject(input logic [1:0] p, input logic c, input logic u);
    sf_pre = p; sf_c = c; sf_u = u; sf_valid = 1'b1;
    @(negedge clk);
    sf_valid = 1'b0; sf_pre = 2'd0;
  endtask

  task automatic model_reset();
    seen = 0; restarted = 0; lastz = -100; frame_n = 0;
    mac = 0; mau = 0; mbc = 0; mbu = 0;
  endtask

  task automatic do_reset(input logic m, input bit check_rst);
    rst = 1'b1; master = m;
    repeat (4) @(negedge clk);
    if (check_rst) begin
      check("R1", "wclk in reset", wclk_o, 0);
      check("R1", "c in reset", c_o, 0);
      check("R1", "u in reset", u_o, 0);
      check("R1", "mark in reset", blk_mark_o, 0);
    end
    rst = 1'b0;
    model_reset();
  endtask

  task automatic run_frame(input logic [6:0] v);
    string tc, tu, tm;
    int d, ec, eu, em;
    wait_level(1'b1);
    d  = frame_n - lastz;
    ec = (hw && seen) ? int'(mac) : 0;
    eu = seen ? int'(mau) : 0;
    em = (hw && lastz >= 0 && d >= 2 && d <= 17) ? 1 : 0;
    tc = !seen ? "R6" : (hw ? "R5" : "R10");
    tu = seen ? "R5" : "R6";
    if (!hw)           tm = "R10";
    else if (lastz < 0) tm = "R6";
    else if (restarted) tm = "R9";
    else if (d == 2)    tm = "R7";
    else                tm = "R8";
    check(tc, "c at rise", c_o, ec);
    check(tu, "u at rise", u_o, eu);
    check(tm, "mark at rise", blk_mark_o, em);
    repeat (2) @(negedge clk);
    check("R4", "c steady in high phase", c_o, ec);
    check("R4", "mark steady in high phase", blk_mark_o, em);
    if (v[6]) begin
      if (v[5] && lastz >= 0 && d >= 2 && d <= 17) restarted = 1;
      inject(v[5] ? 2'd1 : 2'd2, v[3], v[2]);
      mac = v[3]; mau = v[2];
      if (v[5]) begin seen = 1; lastz = frame_n; end
    end
    wait_level(1'b0);
    ec = (hw && seen) ? int'(mbc) : 0;
    eu = seen ? int'(mbu) : 0;
    check(!seen ? "R6" : (hw ? "R5" : "R10"), "c at fall", c_o, ec);
    check(seen ? "R5" : "R6", "u at fall", u_o, eu);
    repeat (2) @(negedge clk);
    check("R4", "u steady in low phase", u_o, eu);
    if (v[4]) begin
      inject(2'd3, v[1], v[0]);
      mbc = v[1]; mbu = v[0];
    end
    frame_n++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int cnt;
    rst = 1'b1; master = 1'b1; hw_mode = 1'b1; hw = 1; wclk_ext = 1'b0;
    sf_valid = 1'b0; sf_pre = 2'd0; sf_c = 1'b0; sf_u = 1'b0;
    do_reset(1'b1, 1);

    // R2: phase lengths in master mode
    wait_level(1'b1);
    wait_level(1'b0);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (wclk_o == 1'b0);
    check("R2", "low phase cycles", cnt, HALF);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (wclk_o == 1'b1);
    check("R2", "high phase cycles", cnt, HALF);
    frame_n = 0;

    // table walk: R4..R9 in master mode
    for (int i = 0; i < 32; i++) run_frame(VEC[i]);

    // R10: hardware mode off, Z arrives, then mode restored
    hw_mode = 1'b0; hw = 0;
    run_frame(7'h7F);
    for (int i = 0; i < 3; i++) run_frame(7'h5F);
    hw_mode = 1'b1; hw = 1;
    for (int i = 0; i < 3; i++) run_frame(7'h13);

    // R3: slave mode latency, then frames on the external clock
    do_reset(1'b0, 0);
    repeat (3) @(negedge clk);
    wclk_ext = 1'b1;
    repeat (3) @(negedge clk);
    check("R3", "wclk before latency", wclk_o, 0);
    @(negedge clk);
    check("R3", "wclk after latency", wclk_o, 1);
    ext_cnt = 0;
    ext_run = 1;
    wait_level(1'b0);
    frame_n = 0;
    for (int i = 0; i < 22; i++) begin
      if (i == 1)          run_frame(7'h79);
      else if (i % 3 == 0) run_frame(7'h56);
      else                 run_frame(7'h13);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule